// File: doc/BRIEF.md
# String Descriptor Table Walker

This block answers requests for USB string descriptors from a table packed into a 256-byte configuration memory. Each request carries a string index and the byte count the host asked for. The table begins at a fixed address, and each entry in it starts with its own length. The block reads the length at the current position and hops by it to the next entry. It repeats this until it reaches the wanted index or meets a terminator. It then reads the whole descriptor back from the memory and sends it on a byte stream with valid/ready handshaking. The stream is cut to the host's byte count.

Every request ends with a one-cycle completion pulse. The pulse carries the entry length and a hit flag. An index that cannot be served gets a completion with length zero and no stream bytes, not an error. The USB control stages and packet framing sit outside this block. The memory has a synchronous read port with one cycle of latency.

Top module: `strwalk_walker`

## Requirements
- R1: After reset, req_ready is 1, out_valid is 0 and rsp_done is 0.
- R2: Entry k is found by starting at byte address 16 and adding the length byte of each earlier entry. The streamed bytes are the memory bytes of that entry, in address order from its first byte: the length byte, then the type byte 0x03, then the text.
- R3: The number of bytes streamed equals the smaller of the entry length byte and req_wlength. out_last is 1 on the final byte and 0 on every other byte.
- R4: On a hit, rsp_done comes with rsp_hit=1 and rsp_len equal to the entry's length byte.
- R5: When the walk meets a length byte of 0 at or before the requested index, the response has rsp_hit=0, rsp_len=0 and no stream bytes.
- R6: A length byte of 1 ends the walk in the same way as a length byte of 0.
- R7: A type byte other than 0x03, at or before the requested index, gives a zero-length miss.
- R8: A zero-length miss results in either of two cases. The first is an entry whose last byte would lie above address 255. The second is a hop to a next entry whose start would lie above address 255.
- R9: A request with index above 6 gets a zero-length miss on the cycle after it is accepted. No memory read is issued for it.
- R10: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values on the next cycle.
- R11: When the entry is found and req_wlength is 0, the response has rsp_hit=1 and rsp_len equal to the length byte, and no bytes are streamed.
- R12: A request is accepted only while req_ready is 1. req_ready is 1 only in the idle state. Each accepted request produces exactly one rsp_done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken on this cycle |
| req_index | input | 8 | String index requested |
| req_wlength | input | 16 | Byte count asked by the host |
| mem_rd_en | output | 1 | Configuration memory read strobe |
| mem_addr | output | 8 | Configuration memory byte address |
| mem_rdata | input | 8 | Read data, one cycle after the strobe |
| out_valid | output | 1 | Stream byte present |
| out_ready | input | 1 | Consumer takes the byte |
| out_data | output | 8 | Stream byte |
| out_last | output | 1 | Final byte of the response |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_len | output | 8 | Entry length byte on a hit, 0 on a miss |
| rsp_hit | output | 1 | Requested entry was found |

## Verification
Six table images are each swept over every index from 0 to 7. Each index is tried with host byte counts of 0, 1 and 3, one less than the entry length, the entry length itself, and 0xFFFF. This separates truncation from full delivery and the wrong-entry case from the wrong-offset case. The images cover the following: a clean chain; a full seven-entry chain; a bad type byte; a length byte of one; an entry that runs past the top of memory; and a hop that lands exactly on address 256. Each image tells apart one way the walk can stop early from a correct hit. A pseudo-random ready pattern stalls the stream throughout, so that lost, repeated or reordered bytes show up.

// File: rtl/strwalk_pkg.sv
package strwalk_pkg;

    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_RD_LEN   = 4'd1,
        ST_CHK_LEN  = 4'd2,
        ST_RD_TYPE  = 4'd3,
        ST_CHK_TYPE = 4'd4,
        ST_RD_BYTE  = 4'd5,
        ST_LOAD     = 4'd6,
        ST_SEND     = 4'd7,
        ST_DONE     = 4'd8
    } walk_st_e;

    localparam int DEF_ADDR_W     = 8;
    localparam int DEF_TABLE_BASE = 16;
    localparam int DEF_MAX_INDEX  = 6;
    localparam int DEF_WLEN_W     = 16;
    localparam logic [7:0] DEF_DESC_TYPE = 8'h03;

endpackage

// File: rtl/strwalk_span.sv
// Address arithmetic for one entry: does it fit, may the walk hop past it.
module strwalk_span #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [7:0]        elen,
    output logic              fits,
    output logic              hop_ok,
    output logic [ADDR_W-1:0] next_base
);
    localparam int SPACE = 1 << ADDR_W;
    localparam int SUM_W = ((ADDR_W > 8) ? ADDR_W : 8) + 2;

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum       = SUM_W'(base) + SUM_W'(elen);
        fits      = (sum <= SUM_W'(SPACE));
        hop_ok    = (sum <  SUM_W'(SPACE));
        next_base = sum[ADDR_W-1:0];
    end
endmodule

// File: rtl/strwalk_clip.sv
// Bytes to send: the smaller of entry length and host byte count.
module strwalk_clip #(
    parameter int WLEN_W = 16
) (
    input  logic [7:0]        elen,
    input  logic [WLEN_W-1:0] wlen,
    output logic [7:0]        cnt
);
    localparam int CMP_W = (WLEN_W > 8) ? WLEN_W : 8;

    always_comb begin
        if (CMP_W'(elen) <= CMP_W'(wlen)) cnt = elen;
        else                              cnt = 8'(wlen);
    end
endmodule

// File: rtl/strwalk_walker.sv
module strwalk_walker
    import strwalk_pkg::*;
#(
    parameter int         ADDR_W     = DEF_ADDR_W,
    parameter int         TABLE_BASE = DEF_TABLE_BASE,
    parameter int         MAX_INDEX  = DEF_MAX_INDEX,
    parameter int         WLEN_W     = DEF_WLEN_W,
    parameter logic [7:0] DESC_TYPE  = DEF_DESC_TYPE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_index,
    input  logic [WLEN_W-1:0] req_wlength,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_last,
    output logic              rsp_done,
    output logic [7:0]        rsp_len,
    output logic              rsp_hit
);
    localparam int IDX_W = (MAX_INDEX < 1) ? 1 : $clog2(MAX_INDEX + 1);

    typedef struct packed {
        walk_st_e          st;
        logic [ADDR_W-1:0] base;
        logic [IDX_W-1:0]  cur;
        logic [IDX_W-1:0]  want;
        logic [WLEN_W-1:0] wl;
        logic [7:0]        elen;
        logic [7:0]        cnt;
        logic [7:0]        pos;
        logic [7:0]        data;
        logic              last;
        logic              hit;
        logic [7:0]        rlen;
    } wstate_t;

    wstate_t           r_q, r_d;
    logic [7:0]        span_len;
    logic              span_fits, span_hop_ok;
    logic [ADDR_W-1:0] span_next;
    logic [7:0]        clip_cnt;

    assign span_len = (r_q.st == ST_CHK_LEN) ? mem_rdata : r_q.elen;

    strwalk_span #(.ADDR_W(ADDR_W)) u_span (
        .base      (r_q.base),
        .elen      (span_len),
        .fits      (span_fits),
        .hop_ok    (span_hop_ok),
        .next_base (span_next)
    );

    strwalk_clip #(.WLEN_W(WLEN_W)) u_clip (
        .elen (r_q.elen),
        .wlen (r_q.wl),
        .cnt  (clip_cnt)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.hit  = 1'b0;
                    r_d.rlen = 8'd0;
                    if (req_index > 8'(MAX_INDEX)) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.want = req_index[IDX_W-1:0];
                        r_d.cur  = '0;
                        r_d.base = ADDR_W'(TABLE_BASE);
                        r_d.wl   = req_wlength;
                        r_d.st   = ST_RD_LEN;
                    end
                end
            end
            ST_RD_LEN:  r_d.st = ST_CHK_LEN;
            ST_CHK_LEN: begin
                // terminator (0), malformed (1) or overrun ends the walk
                if (mem_rdata < 8'd2 || !span_fits) begin
                    r_d.st = ST_DONE;
                end else begin
                    r_d.elen = mem_rdata;
                    r_d.st   = ST_RD_TYPE;
                end
            end
            ST_RD_TYPE: r_d.st = ST_CHK_TYPE;
            ST_CHK_TYPE: begin
                if (mem_rdata != DESC_TYPE) begin
                    r_d.st = ST_DONE;
                end else if (r_q.cur == r_q.want) begin
                    r_d.hit  = 1'b1;
                    r_d.rlen = r_q.elen;
                    r_d.cnt  = clip_cnt;
                    r_d.pos  = 8'd0;
                    r_d.st   = (clip_cnt == 8'd0) ? ST_DONE : ST_RD_BYTE;
                end else if (!span_hop_ok) begin
                    r_d.st = ST_DONE;
                end else begin
                    r_d.base = span_next;
                    r_d.cur  = r_q.cur + IDX_W'(1);
                    r_d.st   = ST_RD_LEN;
                end
            end
            ST_RD_BYTE: r_d.st = ST_LOAD;
            ST_LOAD: begin
                r_d.data = mem_rdata;
                r_d.last = ((r_q.pos + 8'd1) == r_q.cnt);
                r_d.st   = ST_SEND;
            end
            ST_SEND: begin
                if (out_ready) begin
                    if (r_q.last) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.pos = r_q.pos + 8'd1;
                        r_d.st  = ST_RD_BYTE;
                    end
                end
            end
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        mem_rd_en = 1'b0;
        mem_addr  = r_q.base;
        case (r_q.st)
            ST_RD_LEN:  mem_rd_en = 1'b1;
            ST_RD_TYPE: begin
                mem_rd_en = 1'b1;
                mem_addr  = r_q.base + ADDR_W'(1);
            end
            ST_RD_BYTE: begin
                mem_rd_en = 1'b1;
                mem_addr  = r_q.base + ADDR_W'(r_q.pos);
            end
            default: ;
        endcase
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign out_valid = (r_q.st == ST_SEND);
    assign out_data  = r_q.data;
    assign out_last  = r_q.last;
    assign rsp_done  = (r_q.st == ST_DONE);
    assign rsp_len   = r_q.rlen;
    assign rsp_hit   = r_q.hit;
endmodule

// File: rtl/strwalk_chk.sv
module strwalk_chk #(
    parameter int ADDR_W     = 8,
    parameter int TABLE_BASE = 16,
    parameter int MAX_INDEX  = 6,
    parameter int WLEN_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [7:0]        req_index,
    input logic [WLEN_W-1:0] req_wlength,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_data,
    input logic              out_last,
    input logic              rsp_done,
    input logic [7:0]        rsp_len,
    input logic              rsp_hit
);
    localparam int CMP_W = (WLEN_W > 8) ? WLEN_W : 8;

    logic [7:0]        beats;
    logic [WLEN_W-1:0] wl_cap;
    logic [CMP_W-1:0]  exp_beats;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beats  <= 8'd0;
            wl_cap <= '0;
        end else if (req_valid && req_ready) begin
            beats  <= 8'd0;
            wl_cap <= req_wlength;
        end else if (out_valid && out_ready) begin
            beats  <= beats + 8'd1;
        end
    end

    always_comb begin
        if (!rsp_hit)                             exp_beats = '0;
        else if (CMP_W'(rsp_len) <= CMP_W'(wl_cap)) exp_beats = CMP_W'(rsp_len);
        else                                      exp_beats = CMP_W'(wl_cap);
    end

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R3
    beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> (CMP_W'(beats) == exp_beats));

    // R3
    last_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> rsp_done);

    // R9
    reject_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_index > 8'(MAX_INDEX)) |=> (rsp_done && !rsp_hit && !mem_rd_en));

    // R5
    miss_len_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !rsp_hit) |-> (rsp_len == 8'd0));

    // R12
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R12
    stream_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid || rsp_done) |-> !req_ready);

    // R2
    read_in_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (mem_addr >= ADDR_W'(TABLE_BASE)));
endmodule

bind strwalk_walker strwalk_chk #(
    .ADDR_W     (ADDR_W),
    .TABLE_BASE (TABLE_BASE),
    .MAX_INDEX  (MAX_INDEX),
    .WLEN_W     (WLEN_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_index   (req_index),
    .req_wlength (req_wlength),
    .mem_rd_en   (mem_rd_en),
    .mem_addr    (mem_addr),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_last    (out_last),
    .rsp_done    (rsp_done),
    .rsp_len     (rsp_len),
    .rsp_hit     (rsp_hit)
);

// File: tb/tb_strwalk_walker.sv
module tb_strwalk_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_index = 8'd0;
    logic [15:0] req_wlength = 16'd0;
    logic        mem_rd_en;
    logic [7:0]  mem_addr;
    logic [7:0]  mem_rdata = 8'd0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        out_last;
    logic        rsp_done;
    logic [7:0]  rsp_len;
    logic        rsp_hit;

    logic [7:0]  mem [0:255];
    int          total = 0;
    int          bad = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    always @(posedge clk) if (mem_rd_en) mem_rdata <= mem[mem_addr];

    strwalk_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_index(req_index), .req_wlength(req_wlength), .mem_rd_en(mem_rd_en),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .rsp_done(rsp_done), .rsp_len(rsp_len), .rsp_hit(rsp_hit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'd0;
    endtask

    task automatic put_entry(input int a, input int len, input int typ);
        mem[a] = 8'(len);
        if (a + 1 < 256) mem[a+1] = 8'(typ);
        for (int i = 2; i < len && a + i < 256; i++) mem[a+i] = 8'((a * 7 + i * 13 + 5) & 255);
    endtask

    // expected result from the requirements: hit, start address, length
    task automatic ref_walk(input int idx, output bit hit, output int start, output int len);
        int a;
        hit = 1'b0; start = 0; len = 0;
        if (idx > 6) return;
        a = 16;
        for (int k = 0; k <= idx; k++) begin
            int l;
            if (a > 255) return;
            l = int'(mem[a]);
            if (l < 2) return;
            if (a + l > 256) return;
            if (mem[a+1] != 8'h03) return;
            if (k == idx) begin hit = 1'b1; start = a; len = l; return; end
            if (a + l > 255) return;
            a = a + l;
        end
    endtask

    task automatic run_req(input int idx, input int wl);
        bit   ehit; int estart, elen, ecnt;
        int   got = 0; bit done = 0; bit saw_rd = 0; bit bytes_ok = 1; bit last_ok = 1;
        int   cyc = 0; bit stalled = 0; logic [7:0] held = 8'd0; logic held_last = 1'b0;
        logic [7:0] r_len = 8'd0; logic r_hit = 1'b0;
        ref_walk(idx, ehit, estart, elen);
        ecnt = ehit ? ((elen < wl) ? elen : wl) : 0;
        @(negedge clk);
        check(req_ready == 1'b1, "R12 ready idle", int'(req_ready), 1);
        req_valid = 1'b1; req_index = 8'(idx); req_wlength = 16'(wl);
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && cyc < 3000) begin
            if (stalled && out_valid)
                check(out_data == held && out_last == held_last, "R10 hold", int'(out_data), int'(held));
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = (lfsr[1:0] != 2'b00);
            stalled = out_valid && !out_ready;
            held = out_data; held_last = out_last;
            if (mem_rd_en) saw_rd = 1'b1;
            if (out_valid && out_ready) begin
                if (got >= ecnt || out_data != mem[(estart + got) & 255]) bytes_ok = 0;
                if (out_last != (got == ecnt - 1)) last_ok = 0;
                got++;
            end
            if (rsp_done) begin done = 1; r_len = rsp_len; r_hit = rsp_hit; end
            @(negedge clk);
            cyc++;
        end
        out_ready = 1'b0;
        check(done, "R12 one completion", int'(done), 1);
        check(got == ecnt, (wl == 0 && ehit) ? "R11 zero wlength count" : "R3 byte count", got, ecnt);
        check(bytes_ok, "R2 entry bytes", int'(bytes_ok), 1);
        check(last_ok, "R3 last flag", int'(last_ok), 1);
        check(r_hit == ehit, ehit ? "R4 hit flag" : "R5 R6 R7 R8 miss flag", int'(r_hit), int'(ehit));
        check(int'(r_len) == elen, ehit ? "R4 length" : "R5 miss length", int'(r_len), elen);
        if (idx > 6) check(!saw_rd, "R9 no read on reject", int'(saw_rd), 0);
    endtask

    task automatic sweep();
        for (int idx = 0; idx < 8; idx++) begin
            bit h; int s, l;
            ref_walk(idx, h, s, l);
            for (int w = 0; w < 6; w++) begin
                int wl;
                case (w)
                    0: wl = 0;
                    1: wl = 1;
                    2: wl = 3;
                    3: wl = (l > 0) ? l - 1 : 2;
                    4: wl = l;
                    default: wl = 16'hFFFF;
                endcase
                run_req(idx, wl);
            end
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        check(rsp_done == 1'b0, "R1 rsp_done", int'(rsp_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && !out_valid && !rsp_done, "R1 after release", int'(req_ready), 1);

        // clean chain ended by a zero length byte (R2, R5)
        clear_mem();
        put_entry(16, 4, 3); put_entry(20, 10, 3); put_entry(30, 8, 3); put_entry(38, 6, 3);
        mem[44] = 8'd0;
        sweep();

        // seven entries, index 7 rejected (R9)
        clear_mem();
        for (int k = 0, a = 16; k < 7; k++) begin put_entry(a, 4 + 2 * k, 3); a += 4 + 2 * k; end
        sweep();

        // bad type byte on index 2 (R7)
        clear_mem();
        put_entry(16, 6, 3); put_entry(22, 6, 3); put_entry(28, 6, 4); put_entry(34, 6, 3);
        sweep();

        // length byte of one on index 1 (R6)
        clear_mem();
        put_entry(16, 8, 3); mem[24] = 8'd1; mem[25] = 8'd3; put_entry(26, 6, 3);
        sweep();

        // entry running past the top of memory (R8)
        clear_mem();
        put_entry(16, 100, 3); put_entry(116, 100, 3); put_entry(216, 50, 3);
        sweep();

        // hop landing exactly on address 256 (R8)
        clear_mem();
        put_entry(16, 120, 3); put_entry(136, 120, 3);
        sweep();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule